// File: doc/BRIEF.md
# Berger-Checked Serial FIR Filter

An unsigned direct-form FIR filter that computes each output with one multiply-accumulate element, stepping through the taps one per clock. Samples arrive on a valid/ready handshake. Each result leaves as a one-cycle valid pulse, and an error flag travels beside it.

The datapath is guarded by ones-count (Berger) prediction. On entry, each sample's ones-count is computed and stored in a count line that shifts in step with the sample history. Each coefficient's ones-count is a constant of the build. On every tap step, a predicted ones-count for the new running sum is formed as count(h)·count(x) + predicted count of the previous sum − count of the accumulator adder's carries − the summed counts of every multiplier row adder's carries. The product's own ones-count is never needed. The predicted count is kept in a register beside the accumulator and is compared with the accumulator's actual ones-count in every cycle. Any difference sets a sticky error flag. Because a unidirectional multi-bit upset moves the ones-count in one direction only, every such upset on the accumulator is caught.

A test-only pair of masks can force accumulator bits to 1 or to 0 on every accumulator write, so that detection can be shown working.

Top module: `berger_fir`

## Requirements
- R1: While rst_ni is low, and after it is released: out_valid_o = 0, err_o = 0, in_ready_o = 1, and the sample history and every count are zero.
- R2: A sample is taken on a rising edge where in_valid_i and in_ready_o are both high. in_ready_o then stays low until the cycle in which out_valid_o is high, and it is high again in that cycle.
- R3: out_valid_o is a single-cycle pulse. It becomes high TAPS+1 rising edges after the edge that accepted the sample.
- R4: out_data_o = Σ h[i]·x[i] for i = 0..TAPS-1. Here x[0] is the newest accepted sample, x[i] is the sample accepted i handshakes earlier (zero if none since reset), and h[i] is COEFFS[8i+7:8i].
- R5: The accumulator is 2·DW+log2(TAPS) bits (19 by default) and never wraps. All samples and coefficients at 255 give exactly 520200.
- R6: While both fault masks are zero, err_o stays 0 for any sample stream.
- R7: On each accumulator write, bits set in fault_set_i are forced to 1 and bits set in fault_clr_i are forced to 0, with the clear taking priority. The forced value propagates into later tap steps and into out_data_o.
- R8: A set mask that turns one or more accumulator 0 bits into 1 during a computation makes err_o high no later than that computation's out_valid_o.
- R9: A clear mask that turns one or more accumulator 1 bits into 0 during a computation makes err_o high no later than that computation's out_valid_o.
- R10: Once err_o is high, it stays high through later fault-free computations until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Filter can take a sample |
| in_data_i | input | DW (8) | Unsigned input sample |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | ACC_W (19) | Filter output |
| err_o | output | 1 | Sticky ones-count mismatch flag |
| fault_set_i | input | ACC_W (19) | Test-only: accumulator bits forced to 1 |
| fault_clr_i | input | ACC_W (19) | Test-only: accumulator bits forced to 0 |

## Verification
The bench builds two copies of the filter with the default eight taps and 8-bit data.

The first copy has an asymmetric coefficient set whose sum stays below 512. This keeps every fault-free partial sum under 2^17, so forcing bits 18:17 is a guaranteed 0→1 upset, and an impulse reveals the coefficient order. The second copy has every coefficient at 255. It drives the accumulator to its largest possible value, which exercises the full carry chains and the count prediction at the top of the range.

// File: rtl/berger_fir_pkg.sv
package berger_fir_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} fir_state_e;

  function automatic logic [7:0] ones64(input logic [63:0] v);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < 64; i++) c = c + {7'd0, v[i]};
    return c;
  endfunction

endpackage

// File: rtl/bf_carry_add.sv
// Adder that also reports how many bit positions produced a carry.
module bf_carry_add
  import berger_fir_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     sum_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W:0] full;
  logic [W:0] cin_vec;

  assign full    = {1'b0, a_i} + {1'b0, b_i};
  // carry into bit k is a^b^s at k, so this vector holds every carry out
  assign cin_vec = {1'b0, a_i} ^ {1'b0, b_i} ^ full;
  assign sum_o   = full[W-1:0];
  assign cnt_o   = CNT_W'(ones64(64'(cin_vec)));
endmodule

// File: rtl/bf_check_line.sv
// Sample history with a parallel line of ones-counts.
module bf_check_line
  import berger_fir_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  parameter int TAP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [DW-1:0]    din_i,
  input  logic [TAP_W-1:0] sel_i,
  output logic [DW-1:0]    x_o,
  output logic [CNT_W-1:0] nx_o
);
  logic [DW-1:0]    x_q [TAPS];
  logic [CNT_W-1:0] n_q [TAPS];
  logic [CNT_W-1:0] n_in;

  assign n_in = CNT_W'(ones64(64'(din_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) begin
        x_q[k] <= '0;
        n_q[k] <= '0;
      end
    end else if (shift_i) begin
      x_q[0] <= din_i;
      n_q[0] <= n_in;
      for (int k = 1; k < TAPS; k++) begin
        x_q[k] <= x_q[k-1];
        n_q[k] <= n_q[k-1];
      end
    end
  end

  assign x_o  = x_q[sel_i];
  assign nx_o = n_q[sel_i];
endmodule

// File: rtl/bf_mac_predict.sv
// Row-wise multiplier, accumulator adder and merged ones-count predictor.
module bf_mac_predict
  import berger_fir_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ACC_W = 19,
  parameter int CNT_W = 8
) (
  input  logic [DW-1:0]    h_i,
  input  logic [DW-1:0]    x_i,
  input  logic [CNT_W-1:0] nh_i,
  input  logic [CNT_W-1:0] nx_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [CNT_W-1:0] nacc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0] npred_o
);
  localparam int PW = 2 * DW;

  logic [PW-1:0]    part [DW+1];
  logic [CNT_W-1:0] ncm  [DW];
  logic [CNT_W-1:0] ncm_sum;
  logic [CNT_W-1:0] nca;

  assign part[0] = '0;

  for (genvar j = 0; j < DW; j++) begin : g_row
    logic [PW-1:0] addend;
    assign addend = x_i[j] ? (PW'(h_i) << j) : '0;
    bf_carry_add #(.W(PW), .CNT_W(CNT_W)) u_row (
      .a_i  (part[j]),
      .b_i  (addend),
      .sum_o(part[j+1]),
      .cnt_o(ncm[j])
    );
  end

  always_comb begin
    ncm_sum = '0;
    for (int j = 0; j < DW; j++) ncm_sum = ncm_sum + ncm[j];
  end

  bf_carry_add #(.W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .a_i  (acc_i),
    .b_i  (ACC_W'(part[DW])),
    .sum_o(acc_o),
    .cnt_o(nca)
  );

  // N[h]N[x] + N[S_prev] - N[C_acc] - sum N[C_row] = N[S_new]
  assign npred_o = CNT_W'(nh_i * nx_i) + nacc_i - nca - ncm_sum;
endmodule

// File: rtl/berger_fir.sv
module berger_fir
  import berger_fir_pkg::*;
#(
  parameter int                   TAPS   = 8,
  parameter int                   DW     = 8,
  parameter logic [TAPS*DW-1:0]   COEFFS = {8'd3, 8'd17, 8'd60, 8'd120,
                                            8'd120, 8'd60, 8'd17, 8'd3},
  localparam int                  ACC_W  = 2 * DW + $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [DW-1:0]    in_data_i,
  output logic             out_valid_o,
  output logic [ACC_W-1:0] out_data_o,
  output logic             err_o,
  input  logic [ACC_W-1:0] fault_set_i,
  input  logic [ACC_W-1:0] fault_clr_i
);
  localparam int TAP_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int CNT_W = $clog2(DW * DW + ACC_W + 1) + 1;

  fir_state_e       state_q;
  logic [TAP_W-1:0] tap_q;
  logic [ACC_W-1:0] acc_q, acc_nxt, y_q;
  logic [CNT_W-1:0] nacc_q, npred;
  logic             vld_q, err_q;
  logic             accept, mismatch;
  logic [DW-1:0]    x_sel, h_sel;
  logic [CNT_W-1:0] nx_sel, nh_sel;
  logic [CNT_W-1:0] nh_tab [TAPS];

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;

  for (genvar g = 0; g < TAPS; g++) begin : g_ncoef
    assign nh_tab[g] = CNT_W'(ones64(64'(COEFFS[g*DW +: DW])));
  end

  assign h_sel  = COEFFS[tap_q*DW +: DW];
  assign nh_sel = nh_tab[tap_q];

  bf_check_line #(.TAPS(TAPS), .DW(DW), .CNT_W(CNT_W), .TAP_W(TAP_W)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(accept),
    .din_i  (in_data_i),
    .sel_i  (tap_q),
    .x_o    (x_sel),
    .nx_o   (nx_sel)
  );

  bf_mac_predict #(.DW(DW), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_mac (
    .h_i    (h_sel),
    .x_i    (x_sel),
    .nh_i   (nh_sel),
    .nx_i   (nx_sel),
    .acc_i  (acc_q),
    .nacc_i (nacc_q),
    .acc_o  (acc_nxt),
    .npred_o(npred)
  );

  assign mismatch = CNT_W'(ones64(64'(acc_q))) != nacc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      acc_q   <= '0;
      nacc_q  <= '0;
      y_q     <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      err_q <= err_q | mismatch;
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          acc_q   <= fault_set_i & ~fault_clr_i;
          nacc_q  <= '0;
          tap_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          acc_q  <= (acc_nxt | fault_set_i) & ~fault_clr_i;
          nacc_q <= npred;
          tap_q  <= tap_q + 1'b1;
          if (tap_q == TAP_W'(TAPS - 1)) state_q <= ST_DONE;
        end
        ST_DONE: begin
          y_q     <= acc_q;
          vld_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = y_q;
  assign err_o       = err_q;
endmodule

// File: rtl/berger_fir_chk.sv
module berger_fir_chk #(
  parameter int TAPS  = 8,
  parameter int ACC_W = 19
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             err_o,
  input logic [ACC_W-1:0] fault_set_i,
  input logic [ACC_W-1:0] fault_clr_i
);
  localparam int SW = $clog2(TAPS + 3) + 1;

  logic          accept;
  logic [SW-1:0] since_q;
  logic          seen_fault_q;

  assign accept = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q      <= SW'(TAPS + 2);
      seen_fault_q <= 1'b0;
    end else begin
      if (accept) since_q <= '0;
      else if (since_q < SW'(TAPS + 2)) since_q <= since_q + 1'b1;
      seen_fault_q <= seen_fault_q | (|fault_set_i) | (|fault_clr_i);
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !in_ready_o);

  p_ready_with_result_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> in_ready_o);

  p_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> since_q == SW'(TAPS + 1));

  p_clean_no_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_fault_q |-> !err_o);

  p_set_caught_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && |(fault_set_i & ~fault_clr_i)) |-> ##2 err_o);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind berger_fir berger_fir_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .err_o      (err_o),
  .fault_set_i(fault_set_i),
  .fault_clr_i(fault_clr_i)
);

// File: tb/tb_berger_fir.sv
`timescale 1ns/1ps
module tb_berger_fir;
  localparam int TAPS = 8;
  localparam int AW   = 19;
  // h[i] at bits [8i+7:8i]
  localparam logic [63:0] CA = {8'd2, 8'd18, 8'd61, 8'd121, 8'd120, 8'd60, 8'd17, 8'd3};
  localparam logic [63:0] CB = {8{8'd255}};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic [AW-1:0] fset = '0, fclr = '0;
  logic          rdy_a, rdy_b, vld_a, vld_b, err_a, err_b;
  logic [AW-1:0] y_a, y_b;

  int total = 0;
  int bad   = 0;
  logic [7:0] hist [TAPS];

  always #4 clk = ~clk;

  berger_fir #(.TAPS(TAPS), .DW(8), .COEFFS(CA)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy_a),
    .in_data_i(in_data), .out_valid_o(vld_a), .out_data_o(y_a), .err_o(err_a),
    .fault_set_i(fset), .fault_clr_i(fclr));

  berger_fir #(.TAPS(TAPS), .DW(8), .COEFFS(CB)) dut_max (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy_b),
    .in_data_i(in_data), .out_valid_o(vld_b), .out_data_o(y_b), .err_o(err_b),
    .fault_set_i(fset), .fault_clr_i(fclr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] conv(input logic [63:0] cf);
    logic [AW-1:0] s = '0;
    for (int i = 0; i < TAPS; i++) s = s + AW'(cf[i*8 +: 8]) * AW'(hist[i]);
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 valid in reset", {30'd0, vld_a, vld_b}, 0);
    check("R1 err in reset", {30'd0, err_a, err_b}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {30'd0, rdy_a, rdy_b}, 3);
    check("R1 err after reset R10", {30'd0, err_a, err_b}, 0);
    check("R1 valid after reset", {30'd0, vld_a, vld_b}, 0);
    for (int i = 0; i < TAPS; i++) hist[i] = '0;
  endtask

  task automatic send(input logic [7:0] d, input logic [AW-1:0] s, input logic [AW-1:0] c,
                      input string req, input logic exp_err);
    int lat, early;
    logic [AW-1:0] ea, eb;
    @(negedge clk);
    check("R2 ready before send", {31'd0, rdy_a}, 1);
    in_valid = 1'b1; in_data = d; fset = s; fclr = c;
    for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = d;
    ea = (conv(CA) | s) & ~c;
    eb = conv(CB);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0; early = 0;
    while (!vld_a && lat < 40) begin
      if (rdy_a || rdy_b) early++;
      @(negedge clk);
      lat++;
    end
    check("R2 ready low while busy", early, 0);
    check("R3 latency", lat, TAPS + 1);
    check("R3 both valid", {31'd0, vld_b}, 1);
    check("R2 ready with result", {30'd0, rdy_a, rdy_b}, 3);
    check({req, " data"}, y_a, ea);
    if (s == '0 && c == '0) check({req, " data max R5"}, y_b, eb);
    check({req, " err"}, {30'd0, err_a, err_b}, {30'd0, exp_err, exp_err});
    @(negedge clk);
    check("R3 pulse ends", {30'd0, vld_a, vld_b}, 0);
    fset = '0; fclr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R3 actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < TAPS; i++) hist[i] = '0;
    rst_ni = 1'b0;
    do_reset();
    // impulse reveals coefficient order
    send(8'd1, '0, '0, "R4 impulse", 1'b0);
    for (int k = 1; k < TAPS + 1; k++) send(8'd0, '0, '0, "R4 impulse tail", 1'b0);
    for (int k = 0; k < TAPS; k++) send(8'd255, '0, '0, "R5 full scale", 1'b0);
    check("R5 max value", y_b, 520200);
    for (int k = 0; k < 40; k++) send(8'($urandom_range(0, 255)), '0, '0, "R4 R6 random", 1'b0);
    send(8'h80, '0, '0, "R6 single bit", 1'b0);
    send(8'h7f, '0, '0, "R6 seven bits", 1'b0);
    // 0->1 on bits 18:17, never set by a fault-free partial sum of dut
    send(8'($urandom_range(0, 255)), 19'h60000, '0, "R7 R8 set fault", 1'b1);
    send(8'd9, '0, '0, "R10 sticky", 1'b1);
    do_reset();
    send(8'd44, '0, '0, "R10 cleared R4", 1'b0);
    send(8'd5, '0, 19'h7ffff, "R7 R9 clear fault", 1'b1);
    send(8'd0, '0, '0, "R10 sticky after clear", 1'b1);
    do_reset();
    for (int k = 0; k < 30; k++) send(8'($urandom_range(0, 255)), '0, '0, "R4 R6 random2", 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule